// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an 8-bit parallel NOR flash device that is wired in byte mode. A client hands it one high-level request at a time over a valid/ready port. The four requests are: program a single byte, fetch the two identifier bytes, erase the whole device, and erase one sector. The sequencer expands each request into the command write cycles the device expects. It first issues the two unlock writes and then the command-specific writes. After that it performs any reads, inserts settle delays where the device needs time, and waits for the device's internal program or erase operation to finish.

Completion is detected by toggle polling. The same address is read twice back to back, and the operation counts as finished once bit 6 matches in both reads. If bit 6 keeps changing for more polling pairs than the client-supplied limit, the sequencer gives up. It then writes the reset command (0xF0) and reports completion with an error flag. Bus timing is set by parameters: the write-enable and read-strobe widths in clock cycles, and the settle delay, which is computed from the clock frequency in MHz and a delay in microseconds.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, `done` is 0, both `fl_we_n` and `fl_re_n` are 1, and `fl_drive` is 0.
- R2: Every request starts with two unlock writes. The first writes data 0xAA to address 0xAAA. The second writes data 0x55 to address 0x555.
- R3: Request code 0 (program) continues with 0xA0 to 0xAAA, then writes `req_data` to `req_addr`, and then polls at `req_addr`. A successful program makes 4 writes in total.
- R4: Request code 1 (identify) continues with 0x90 to 0xAAA. It then reads offset 0 into `id_mfr` and offset 2 into `id_dev`. It leaves identifier mode with the unlock pair followed by 0xF0 to 0xAAA, for 6 writes in total.
- R5: Request code 2 (chip erase) makes six writes: the unlock pair, 0x80 to 0xAAA, the unlock pair again, and 0x10 to 0xAAA. It then polls at address 0.
- R6: Request code 3 (sector erase) makes the same six writes as R5, except that the last write is 0x30 to `req_addr`.
- R7: After the 0x90 identify command, and after the final erase write, at least CLK_MHZ*SETTLE_US clock cycles pass before the next read strobe starts.
- R8: Each write holds `fl_we_n` low for exactly WE_CYC cycles with `fl_drive` high and with address and data stable. `fl_we_n` and `fl_re_n` are never low at the same time.
- R9: A poll finishes only after two consecutive reads whose bit 6 values are equal. While bit 6 differs between the two reads of a pair, polling continues.
- R10: If `poll_limit` polling pairs have all toggled, the sequencer writes 0xF0 to 0xAAA and then pulses `done` with `err`=1. This adds one write to the R3/R5/R6 count. `err` is 1 only while `done` is 1.
- R11: `req_ready` is 0 from acceptance until `done`, and a `req_valid` during that time is ignored. `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 2 | 0 program, 1 identify, 2 chip erase, 3 sector erase |
| req_addr | input | AW | Program destination or sector address |
| req_data | input | 8 | Byte to program |
| poll_limit | input | PLW | Maximum polling pairs before timeout |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| id_mfr | output | 8 | Manufacturer byte from the last identify |
| id_dev | output | 8 | Device byte from the last identify |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Data toward the flash |
| fl_din | input | 8 | Data from the flash |
| fl_drive | output | 1 | Host drives the data bus |
| fl_we_n | output | 1 | Write enable, active low |
| fl_re_n | output | 1 | Output enable, active low |

## Verification
The bench targets several ways the sequence can go wrong. A sector erase whose confirm went to 0xAAA would erase nothing at the target, and one that went to address 0 would erase the wrong sector; comparing every logged write catches both. It also looks for a poll that stops on the first stable read instead of a stable pair, and for a second identifier byte read at offset 1, which would return a wrong device code. A settle counter that is too short shows up as a read strobe that starts before the delay has elapsed. The timeout path is driven by a device that toggles forever. A design that never gave up would hang, and one that skipped the 0xF0 write would leave one write short. A request raised while busy would show up as extra erase writes.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

   typedef enum logic [1:0] {
      OP_PROG  = 2'd0,
      OP_IDENT = 2'd1,
      OP_CHIP  = 2'd2,
      OP_SECT  = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      K_WR,
      K_RD_MFR,
      K_RD_DEV,
      K_WAIT,
      K_POLL,
      K_FIN
   } step_kind_e;

   typedef enum logic [2:0] {
      A_UNL_HI,
      A_UNL_LO,
      A_TGT,
      A_ZERO,
      A_TWO
   } addr_sel_e;

   typedef struct packed {
      step_kind_e kind;
      addr_sel_e  asel;
      logic       use_data;
      logic [7:0] cmd;
   } step_t;

   typedef enum logic [3:0] {
      S_IDLE,
      S_FETCH,
      S_BUS,
      S_DELAY,
      S_PA_ISS,
      S_PA_WAIT,
      S_PB_ISS,
      S_PB_WAIT,
      S_RST_ISS,
      S_RST_WAIT,
      S_DONE
   } seq_st_e;

   typedef enum logic [1:0] {
      B_IDLE,
      B_SETUP,
      B_STROBE,
      B_HOLD
   } bus_st_e;

   localparam logic [7:0] CMD_UNL1  = 8'hAA;
   localparam logic [7:0] CMD_UNL2  = 8'h55;
   localparam logic [7:0] CMD_PROG  = 8'hA0;
   localparam logic [7:0] CMD_IDENT = 8'h90;
   localparam logic [7:0] CMD_ERSET = 8'h80;
   localparam logic [7:0] CMD_CHIP  = 8'h10;
   localparam logic [7:0] CMD_SECT  = 8'h30;
   localparam logic [7:0] CMD_RESET = 8'hF0;

endpackage

// File: rtl/nor_step_table.sv
module nor_step_table
   import nor_seq_pkg::*;
(
   input  op_e        op,
   input  logic [3:0] idx,
   output step_t      step
);

   function automatic step_t mk(step_kind_e k, addr_sel_e a, logic u, logic [7:0] c);
      step_t s;
      s.kind     = k;
      s.asel     = a;
      s.use_data = u;
      s.cmd      = c;
      return s;
   endfunction

   always_comb begin
      step = mk(K_FIN, A_ZERO, 1'b0, 8'h00);
      if (idx == 4'd0) begin
         step = mk(K_WR, A_UNL_HI, 1'b0, CMD_UNL1);
      end else if (idx == 4'd1) begin
         step = mk(K_WR, A_UNL_LO, 1'b0, CMD_UNL2);
      end else begin
         case (op)
            OP_PROG: begin
               case (idx)
                  4'd2:    step = mk(K_WR,   A_UNL_HI, 1'b0, CMD_PROG);
                  4'd3:    step = mk(K_WR,   A_TGT,    1'b1, 8'h00);
                  4'd4:    step = mk(K_POLL, A_TGT,    1'b0, 8'h00);
                  default: step = mk(K_FIN,  A_ZERO,   1'b0, 8'h00);
               endcase
            end
            OP_IDENT: begin
               case (idx)
                  4'd2:    step = mk(K_WR,     A_UNL_HI, 1'b0, CMD_IDENT);
                  4'd3:    step = mk(K_WAIT,   A_ZERO,   1'b0, 8'h00);
                  4'd4:    step = mk(K_RD_MFR, A_ZERO,   1'b0, 8'h00);
                  4'd5:    step = mk(K_RD_DEV, A_TWO,    1'b0, 8'h00);
                  4'd6:    step = mk(K_WR,     A_UNL_HI, 1'b0, CMD_UNL1);
                  4'd7:    step = mk(K_WR,     A_UNL_LO, 1'b0, CMD_UNL2);
                  4'd8:    step = mk(K_WR,     A_UNL_HI, 1'b0, CMD_RESET);
                  4'd9:    step = mk(K_WAIT,   A_ZERO,   1'b0, 8'h00);
                  default: step = mk(K_FIN,    A_ZERO,   1'b0, 8'h00);
               endcase
            end
            default: begin
               case (idx)
                  4'd2:    step = mk(K_WR, A_UNL_HI, 1'b0, CMD_ERSET);
                  4'd3:    step = mk(K_WR, A_UNL_HI, 1'b0, CMD_UNL1);
                  4'd4:    step = mk(K_WR, A_UNL_LO, 1'b0, CMD_UNL2);
                  4'd5:    step = (op == OP_SECT) ? mk(K_WR, A_TGT,    1'b0, CMD_SECT)
                                                  : mk(K_WR, A_UNL_HI, 1'b0, CMD_CHIP);
                  4'd6:    step = mk(K_WAIT, A_ZERO, 1'b0, 8'h00);
                  4'd7:    step = mk(K_POLL, A_ZERO, 1'b0, 8'h00);
                  default: step = mk(K_FIN,  A_ZERO, 1'b0, 8'h00);
               endcase
            end
         endcase
      end
   end

endmodule

// File: rtl/nor_delay_timer.sv
module nor_delay_timer #(
   parameter int CYC = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);

   localparam int CW = $clog2(CYC + 1);

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("nor_delay_timer: CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= CW'(CYC);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == CW'(1));

   assert_expire_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      expired && !start |=> !expired);

endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
   import nor_seq_pkg::*;
#(
   parameter int AW     = 20,
   parameter int WE_CYC = 3,
   parameter int RD_CYC = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rd,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic          done,
   output logic [7:0]    rdata,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dout,
   input  logic [7:0]    fl_din,
   output logic          fl_drive,
   output logic          fl_we_n,
   output logic          fl_re_n
);

   localparam int MAXC = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (WE_CYC < 1 || RD_CYC < 1) begin : g_bad_width
         $error("nor_bus_cycle: strobe widths must be at least 1");
      end
   endgenerate

   bus_st_e       st;
   logic [CW-1:0] cnt;
   logic          rd_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    data_q;
   logic [7:0]    rdata_q;
   logic          last_strobe;

   generate
      if (WE_CYC == RD_CYC) begin : g_same_width
         assign last_strobe = (cnt == CW'(WE_CYC - 1));
      end else begin : g_split_width
         assign last_strobe = rd_q ? (cnt == CW'(RD_CYC - 1)) : (cnt == CW'(WE_CYC - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= B_IDLE;
         cnt     <= '0;
         rd_q    <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
         rdata_q <= '0;
      end else begin
         case (st)
            B_IDLE: if (start) begin
               rd_q   <= rd;
               addr_q <= addr;
               data_q <= wdata;
               st     <= B_SETUP;
            end
            B_SETUP: begin
               cnt <= '0;
               st  <= B_STROBE;
            end
            B_STROBE: if (last_strobe) begin
               if (rd_q) rdata_q <= fl_din;
               st <= B_HOLD;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: st <= B_IDLE;
         endcase
      end
   end

   assign done     = (st == B_HOLD);
   assign rdata    = rdata_q;
   assign fl_addr  = addr_q;
   assign fl_dout  = data_q;
   assign fl_drive = (st != B_IDLE) && !rd_q;
   assign fl_we_n  = !((st == B_STROBE) && !rd_q);
   assign fl_re_n  = !((st == B_STROBE) && rd_q);

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_re_n));

   assert_we_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout) && fl_drive));

   assert_bus_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_seq_pkg::*;
#(
   parameter int AW        = 20,
   parameter int CLK_MHZ   = 250,
   parameter int SETTLE_US = 10,
   parameter int WE_CYC    = 3,
   parameter int RD_CYC    = 3,
   parameter int PLW       = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [1:0]     req_op,
   input  logic [AW-1:0]  req_addr,
   input  logic [7:0]     req_data,
   input  logic [PLW-1:0] poll_limit,
   output logic           done,
   output logic           err,
   output logic [7:0]     id_mfr,
   output logic [7:0]     id_dev,
   output logic [AW-1:0]  fl_addr,
   output logic [7:0]     fl_dout,
   input  logic [7:0]     fl_din,
   output logic           fl_drive,
   output logic           fl_we_n,
   output logic           fl_re_n
);

   localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
   localparam logic [AW-1:0] ADDR_HI = AW'(12'hAAA);
   localparam logic [AW-1:0] ADDR_LO = AW'(12'h555);

   generate
      if (AW < 12) begin : g_bad_aw
         $error("nor_cmd_seq: AW must cover the unlock addresses");
      end
      if (PLW < 1) begin : g_bad_plw
         $error("nor_cmd_seq: PLW must be at least 1");
      end
   endgenerate

   seq_st_e        st;
   op_e            op_q;
   logic [AW-1:0]  addr_q;
   logic [7:0]     data_q;
   logic [3:0]     idx_q;
   logic           err_q;
   logic           b6_q;
   logic [PLW-1:0] pair_cnt;
   logic [AW-1:0]  poll_addr_q;
   logic [7:0]     id_mfr_q;
   logic [7:0]     id_dev_q;

   step_t          step;
   logic           bus_start;
   logic           bus_rd;
   logic [AW-1:0]  bus_addr;
   logic [7:0]     bus_wdata;
   logic           bus_done;
   logic [7:0]     bus_rdata;
   logic           tmr_start;
   logic           tmr_exp;
   logic           last_pair;

   function automatic logic [AW-1:0] pick_addr(addr_sel_e s, logic [AW-1:0] tgt);
      case (s)
         A_UNL_HI: return ADDR_HI;
         A_UNL_LO: return ADDR_LO;
         A_TGT:    return tgt;
         A_TWO:    return AW'(2);
         default:  return '0;
      endcase
   endfunction

   nor_step_table u_table (
      .op   (op_q),
      .idx  (idx_q),
      .step (step)
   );

   nor_delay_timer #(.CYC(SETTLE_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_start),
      .expired (tmr_exp)
   );

   nor_bus_cycle #(.AW(AW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (bus_start),
      .rd       (bus_rd),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .done     (bus_done),
      .rdata    (bus_rdata),
      .fl_addr  (fl_addr),
      .fl_dout  (fl_dout),
      .fl_din   (fl_din),
      .fl_drive (fl_drive),
      .fl_we_n  (fl_we_n),
      .fl_re_n  (fl_re_n)
   );

   assign last_pair = ({1'b0, pair_cnt} + 1'b1) >= {1'b0, poll_limit};

   always_comb begin
      bus_start = 1'b0;
      bus_rd    = 1'b0;
      bus_addr  = pick_addr(step.asel, addr_q);
      bus_wdata = step.use_data ? data_q : step.cmd;
      tmr_start = 1'b0;
      case (st)
         S_FETCH: begin
            case (step.kind)
               K_WR:     bus_start = 1'b1;
               K_RD_MFR,
               K_RD_DEV: begin
                  bus_start = 1'b1;
                  bus_rd    = 1'b1;
               end
               K_WAIT:   tmr_start = 1'b1;
               default: ;
            endcase
         end
         S_PA_ISS, S_PB_ISS: begin
            bus_start = 1'b1;
            bus_rd    = 1'b1;
            bus_addr  = poll_addr_q;
         end
         S_RST_ISS: begin
            bus_start = 1'b1;
            bus_addr  = ADDR_HI;
            bus_wdata = CMD_RESET;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         op_q        <= OP_PROG;
         addr_q      <= '0;
         data_q      <= '0;
         idx_q       <= '0;
         err_q       <= 1'b0;
         b6_q        <= 1'b0;
         pair_cnt    <= '0;
         poll_addr_q <= '0;
         id_mfr_q    <= '0;
         id_dev_q    <= '0;
      end else begin
         case (st)
            S_IDLE: if (req_valid) begin
               op_q   <= op_e'(req_op);
               addr_q <= req_addr;
               data_q <= req_data;
               idx_q  <= '0;
               err_q  <= 1'b0;
               st     <= S_FETCH;
            end
            S_FETCH: begin
               case (step.kind)
                  K_WR, K_RD_MFR, K_RD_DEV: st <= S_BUS;
                  K_WAIT:                   st <= S_DELAY;
                  K_POLL: begin
                     poll_addr_q <= pick_addr(step.asel, addr_q);
                     pair_cnt    <= '0;
                     st          <= S_PA_ISS;
                  end
                  default:                  st <= S_DONE;
               endcase
            end
            S_BUS: if (bus_done) begin
               if (step.kind == K_RD_MFR) id_mfr_q <= bus_rdata;
               if (step.kind == K_RD_DEV) id_dev_q <= bus_rdata;
               idx_q <= idx_q + 1'b1;
               st    <= S_FETCH;
            end
            S_DELAY: if (tmr_exp) begin
               idx_q <= idx_q + 1'b1;
               st    <= S_FETCH;
            end
            S_PA_ISS:  st <= S_PA_WAIT;
            S_PA_WAIT: if (bus_done) begin
               b6_q <= bus_rdata[6];
               st   <= S_PB_ISS;
            end
            S_PB_ISS:  st <= S_PB_WAIT;
            S_PB_WAIT: if (bus_done) begin
               if (bus_rdata[6] == b6_q) begin
                  idx_q <= idx_q + 1'b1;
                  st    <= S_FETCH;
               end else if (last_pair) begin
                  err_q <= 1'b1;
                  st    <= S_RST_ISS;
               end else begin
                  pair_cnt <= pair_cnt + 1'b1;
                  st       <= S_PA_ISS;
               end
            end
            S_RST_ISS:  st <= S_RST_WAIT;
            S_RST_WAIT: if (bus_done) st <= S_DONE;
            default:    st <= S_IDLE;
         endcase
      end
   end

   assign req_ready = (st == S_IDLE);
   assign done      = (st == S_DONE);
   assign err       = (st == S_DONE) && err_q;
   assign id_mfr    = id_mfr_q;
   assign id_dev    = id_dev_q;

   assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |-> !req_ready);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   assert_quiet_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DELAY) |-> (fl_we_n && fl_re_n));

   assert_timeout_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RST_WAIT && bus_done) |-> (fl_addr == ADDR_HI && fl_dout == CMD_RESET));

endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;

   localparam int AW    = 20;
   localparam int WE_C  = 3;
   localparam int RD_C  = 2;
   localparam int MHZ   = 250;
   localparam int US    = 2;
   localparam int DLY   = MHZ * US;
   localparam int PLW   = 16;
   localparam logic [7:0] MFR = 8'h20;
   localparam logic [7:0] DEV = 8'hD5;

   typedef struct packed {
      logic [1:0]  op;
      logic [19:0] addr;
      logic [7:0]  data;
      logic [7:0]  busy;
      logic        hang;
      logic [3:0]  lim;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 20'h12345, 8'h5A, 8'd3, 1'b0, 4'd8},
      '{2'd1, 20'h00000, 8'h00, 8'd0, 1'b0, 4'd8},
      '{2'd2, 20'h00000, 8'h00, 8'd6, 1'b0, 4'd8},
      '{2'd3, 20'h40000, 8'h00, 8'd4, 1'b0, 4'd8},
      '{2'd0, 20'h00000, 8'h00, 8'd0, 1'b0, 4'd8},
      '{2'd3, 20'h7F000, 8'h00, 8'd0, 1'b1, 4'd5},
      '{2'd0, 20'hFFFFF, 8'hC3, 8'd1, 1'b0, 4'd8}
   };

   logic           clk = 1'b0;
   logic           rst_n;
   logic           req_valid;
   logic           req_ready;
   logic [1:0]     req_op;
   logic [AW-1:0]  req_addr;
   logic [7:0]     req_data;
   logic [PLW-1:0] poll_limit;
   logic           done;
   logic           err;
   logic [7:0]     id_mfr;
   logic [7:0]     id_dev;
   logic [AW-1:0]  fl_addr;
   logic [7:0]     fl_dout;
   logic [7:0]     fl_din;
   logic           fl_drive;
   logic           fl_we_n;
   logic           fl_re_n;

   always #2 clk = ~clk;

   nor_cmd_seq #(.AW(AW), .CLK_MHZ(MHZ), .SETTLE_US(US), .WE_CYC(WE_C),
                 .RD_CYC(RD_C), .PLW(PLW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .poll_limit(poll_limit), .done(done), .err(err), .id_mfr(id_mfr),
      .id_dev(id_dev), .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
      .fl_drive(fl_drive), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n)
   );

   int tests = 0;
   int fails = 0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // flash device model
   logic [27:0] wlog [0:15];
   int          wn = 0;
   logic [7:0]  last_wr_d = 8'h00;
   logic        erase_armed = 1'b0;
   logic        id_mode = 1'b0;
   int          busy_left = 0;
   logic        hang = 1'b0;
   logic        tog = 1'b0;
   int          busy_cfg = 0;
   logic        hang_cfg = 1'b0;
   logic [7:0]  rd_h0 = 8'h00;
   logic [7:0]  rd_h1 = 8'h00;
   int          cyc = 0;
   int          cyc_wr = 0;
   int          we_lo = 0;
   int          width_viol = 0;
   int          gap_viol = 0;
   int          gap_checks = 0;
   int          both_low = 0;

   always_comb begin
      if (id_mode)
         fl_din = (fl_addr == 20'h0) ? MFR : (fl_addr == 20'h2) ? DEV : 8'hFF;
      else if (busy_left > 0 || hang)
         fl_din = {1'b0, tog, 6'h15};
      else
         fl_din = 8'hFF;
   end

   always @(negedge clk) begin
      cyc++;
      if (!fl_we_n) we_lo++;
      if (!fl_we_n && !fl_re_n) both_low++;
   end

   always @(posedge fl_we_n) if (rst_n) begin
      if (we_lo != WE_C || !fl_drive) width_viol++;
      we_lo  = 0;
      cyc_wr = cyc;
      if (wn < 16) wlog[wn] = {fl_addr, fl_dout};
      wn++;
      if (last_wr_d == 8'hA0) begin
         busy_left = busy_cfg; hang = hang_cfg; tog = 1'b0;
      end
      if ((fl_dout == 8'h10 || fl_dout == 8'h30) && erase_armed) begin
         busy_left = busy_cfg; hang = hang_cfg; tog = 1'b0; erase_armed = 1'b0;
      end
      if (fl_dout == 8'h80) erase_armed = 1'b1;
      if (fl_dout == 8'h90 && fl_addr == 20'hAAA) id_mode = 1'b1;
      if (fl_dout == 8'hF0) begin
         id_mode = 1'b0; busy_left = 0; hang = 1'b0;
      end
      last_wr_d = fl_dout;
   end

   always @(negedge fl_re_n) if (rst_n) begin
      if (last_wr_d == 8'h90 || last_wr_d == 8'h10 || last_wr_d == 8'h30) begin
         gap_checks++;
         if (cyc - cyc_wr < DLY) gap_viol++;
      end
   end

   always @(posedge fl_re_n) if (rst_n) begin
      rd_h1 = rd_h0;
      rd_h0 = fl_din;
      if (!id_mode && (busy_left > 0 || hang)) begin
         tog = ~tog;
         if (!hang) busy_left--;
      end
   end

   function automatic logic [27:0] exp_wr(int op, int i, logic [19:0] a, logic [7:0] d);
      if (i == 0) return {20'hAAA, 8'hAA};
      if (i == 1) return {20'h555, 8'h55};
      case (op)
         0: case (i)
               2: return {20'hAAA, 8'hA0};
               3: return {a, d};
               default: return {20'hAAA, 8'hF0};
            endcase
         1: case (i)
               2: return {20'hAAA, 8'h90};
               3: return {20'hAAA, 8'hAA};
               4: return {20'h555, 8'h55};
               default: return {20'hAAA, 8'hF0};
            endcase
         default: case (i)
               2: return {20'hAAA, 8'h80};
               3: return {20'hAAA, 8'hAA};
               4: return {20'h555, 8'h55};
               5: return (op == 3) ? {a, 8'h30} : {20'hAAA, 8'h10};
               default: return {20'hAAA, 8'hF0};
            endcase
      endcase
   endfunction

   function automatic string req_of(int op);
      case (op)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   logic got_done;
   logic got_err;

   task automatic issue(logic [1:0] op, logic [19:0] a, logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R11", "ready low while busy", int'(req_ready), 0);
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done && t < 60000) begin
         @(negedge clk);
         t++;
      end
      got_done = done;
      got_err  = err;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_data = '0;
      poll_limit = 16'd8;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
      chk(done == 1'b0, "R1", "done", int'(done), 0);
      chk(fl_we_n && fl_re_n, "R1", "strobes idle", int'({fl_we_n, fl_re_n}), 3);
      chk(fl_drive == 1'b0, "R1", "drive", int'(fl_drive), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && fl_we_n, "R1", "after release", int'(req_ready), 1);

      // vector walk: R2 R3 R4 R5 R6 R9 R10
      for (int v = 0; v < NV; v++) begin
         int   nexp;
         int   mism;
         vec_t e;
         e = VECS[v];
         busy_cfg = int'(e.busy); hang_cfg = e.hang; poll_limit = PLW'(e.lim);
         wn = 0;
         nexp = (e.op == 2'd0) ? 4 : 6;
         if (e.hang) nexp++;
         issue(e.op, e.addr, e.data);
         wait_done();
         chk(got_done == 1'b1, "R11", "done seen", int'(got_done), 1);
         chk(got_err == e.hang, "R10", "err flag", int'(got_err), int'(e.hang));
         chk(wn == nexp, req_of(int'(e.op)), "write count", wn, nexp);
         mism = 0;
         for (int i = 0; i < nexp && i < 16; i++)
            if (wlog[i] != exp_wr(int'(e.op), i, e.addr, e.data)) mism++;
         chk(mism == 0 && wlog[0] == {20'hAAA, 8'hAA} && wlog[1] == {20'h555, 8'h55},
             "R2", "unlock prefix", mism, 0);
         chk(mism == 0, req_of(int'(e.op)), "write sequence", mism, 0);
         if (e.op == 2'd1) begin
            chk(id_mfr == MFR, "R4", "id_mfr", int'(id_mfr), int'(MFR));
            chk(id_dev == DEV, "R4", "id_dev", int'(id_dev), int'(DEV));
         end else if (!e.hang) begin
            chk(rd_h0[6] == rd_h1[6] && busy_left == 0, "R9", "stable pair at finish",
                int'({rd_h1[6], rd_h0[6]}), int'({rd_h0[6], rd_h0[6]}));
         end else begin
            chk(wlog[nexp-1] == {20'hAAA, 8'hF0}, "R10", "reset write",
                int'(wlog[nexp-1][7:0]), 'hF0);
         end
         @(negedge clk);
         chk(done == 1'b0, "R11", "done pulse width", int'(done), 0);
      end

      // R11: request raised while busy is ignored
      busy_cfg = 5; hang_cfg = 1'b0; poll_limit = 16'd8; wn = 0;
      issue(2'd0, 20'h00100, 8'h11);
      req_valid = 1'b1; req_op = 2'd2;
      repeat (12) @(negedge clk);
      req_valid = 1'b0;
      wait_done();
      repeat (40) @(negedge clk);
      chk(wn == 4, "R11", "busy request ignored", wn, 4);
      chk(req_ready == 1'b1, "R11", "back to idle", int'(req_ready), 1);

      // R10: timeout with single-pair limit during program
      busy_cfg = 0; hang_cfg = 1'b1; poll_limit = 16'd1; wn = 0;
      issue(2'd0, 20'h00200, 8'h22);
      wait_done();
      chk(got_err == 1'b1, "R10", "timeout err", int'(got_err), 1);
      chk(wn == 5 && wlog[4] == {20'hAAA, 8'hF0}, "R10", "timeout write count", wn, 5);
      @(negedge clk);
      chk(err == 1'b0, "R10", "err only with done", int'(err), 0);

      // R7 and R8 accumulated
      chk(gap_checks > 0 && gap_viol == 0, "R7", "settle gap violations", gap_viol, 0);
      chk(width_viol == 0, "R8", "we width violations", width_viol, 0);
      chk(both_low == 0, "R8", "strobe overlap", both_low, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule